// File: doc/BRIEF.md
# Variable Shifter with Carry Out

This block shifts or rotates a data word by an amount held in a register, and returns both the shifted word and the new carry flag. Four operations are supported: logical left, logical right, arithmetic right and rotate right. Only the least significant byte of the amount word counts. As a result, amounts of zero, exactly the data width, and above the data width each have a defined result and carry. An incoming carry is supplied so that the block can return it unchanged when the operation does not define a new one.

An operation enters on a valid/ready input stream and leaves one cycle later on a valid/ready output stream, through a single register stage. The input is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output is held stable and no new input is accepted. An upstream source may present an operation and wait. It must keep the operation stable until it is accepted.

Top module: `shift_carry_unit`

## Requirements
- R1: Only bits [7:0] of `in_amt` form the shift amount. Bits [31:8] have no effect on the result or the carry.
- R2: With an amount of 0, every shift type returns the operand unchanged and passes `in_carry` to `out_carry`.
- R3: Type 0 (logical left), amount k from 1 to 31: the result is the operand shifted left by k and the carry is operand bit 32-k. For k = 32 the result is 0 and the carry is bit 0. For k > 32 the result is 0 and the carry is 0.
- R4: Type 1 (logical right), amount k from 1 to 31: the result is zero-filled from the top and the carry is operand bit k-1. For k = 32 the result is 0 and the carry is bit 31. For k > 32 the result is 0 and the carry is 0.
- R5: Type 2 (arithmetic right), amount k from 1 to 31: the result is sign-filled and the carry is bit k-1. For k >= 32 every result bit equals bit 31, and so does the carry.
- R6: Type 3 (rotate right), nonzero amount k: the rotation is by k mod 32 and the carry is result bit 31 (operand bit (k mod 32)-1). When k mod 32 is 0, the result is the operand and the carry is operand bit 31.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_carry` stay stable.
- R8: While reset is asserted and after it is released, `out_valid` is low until the first input is accepted.
- R9: An operation accepted on one edge is presented on `out_valid`/`out_data`/`out_carry` after that edge, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_data | input | 32 | Operand to shift |
| in_amt | input | 32 | Amount word; low byte is used |
| in_kind | input | 2 | Shift type: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 32 | Shifted or rotated word |
| out_carry | output | 1 | Updated carry flag |

## Verification
The bench builds the block with its default parameters: a 32-bit operand, a 32-bit amount word and an 8-bit amount byte. With these values, the boundary amounts 31, 32, 33 and 255 can all be expressed. Rotations by 32 and 64 can be reached as well, and both wrap to zero. Directed cases with hand-derived results cover each type at these boundaries and with amounts whose upper bits are set. Random traffic with random back-pressure then exercises stalls. A per-bit behavioural model checks every output cycle.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/scu_amount_decode.sv
module scu_amount_decode #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 32,
  parameter int SEL_W  = 8,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0] amt_word,
  output logic [SEL_W-1:0] amt,
  output logic             amt_zero,
  output logic [ROT_W-1:0] rot_amt
);
  logic unused_hi;

  assign amt      = amt_word[SEL_W-1:0];
  assign amt_zero = (amt == '0);
  assign rot_amt  = amt[ROT_W-1:0];
  assign unused_hi = &{1'b0, amt_word[AMT_W-1:SEL_W]};
endmodule

// File: rtl/scu_datapath.sv
module scu_datapath
  import scu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 8,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] x,
  input  logic [SEL_W-1:0]  amt,
  input  logic              amt_zero,
  input  logic [ROT_W-1:0]  rot_amt,
  input  shift_kind_e       kind,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [DATA_W:0]          lsl_ext;
  logic [DATA_W:0]          lsr_ext;
  logic signed [DATA_W:0]   asr_ext;
  logic [2*DATA_W-1:0]      rot_dbl;
  logic [DATA_W-1:0]        rot_res;

  // left: carry lands in the extra top bit
  assign lsl_ext = {1'b0, x} << amt;
  // right: carry lands in the extra bottom bit
  assign lsr_ext = {x, 1'b0} >> amt;
  assign asr_ext = $signed({x, 1'b0}) >>> amt;
  assign rot_dbl = {x, x} >> rot_amt;
  assign rot_res = rot_dbl[DATA_W-1:0];

  always_comb begin
    res  = x;
    cout = cin;
    if (!amt_zero) begin
      unique case (kind)
        SK_LSL: {cout, res} = lsl_ext;
        SK_LSR: {res, cout} = lsr_ext;
        SK_ASR: {res, cout} = asr_ext;
        SK_ROR: begin
          res  = rot_res;
          cout = rot_res[DATA_W-1];
        end
        default: begin
          res  = x;
          cout = cin;
        end
      endcase
    end
  end
endmodule

// File: rtl/scu_out_stage.sv
module scu_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_carry,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_carry
);
  logic load;

  assign up_ready = !dn_valid || dn_ready;
  assign load     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      dn_carry <= 1'b0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (load) begin
        dn_data  <= up_data;
        dn_carry <= up_carry;
      end
    end
  end
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import scu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 32,
  parameter int SEL_W  = 8,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic [1:0]        in_kind,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_carry
);
  logic [SEL_W-1:0]  amt;
  logic              amt_zero;
  logic [ROT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  shift_kind_e       kind;

  assign kind = shift_kind_e'(in_kind);

  scu_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W), .SEL_W(SEL_W)) u_dec (
    .amt_word (in_amt),
    .amt      (amt),
    .amt_zero (amt_zero),
    .rot_amt  (rot_amt)
  );

  scu_datapath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
    .x        (in_data),
    .amt      (amt),
    .amt_zero (amt_zero),
    .rot_amt  (rot_amt),
    .kind     (kind),
    .cin      (in_carry),
    .res      (sh_res),
    .cout     (sh_cout)
  );

  scu_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (sh_res),
    .up_carry (sh_cout),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data),
    .dn_carry (out_carry)
  );
endmodule

// File: rtl/scu_checker.sv
module scu_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 32,
  parameter int SEL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [AMT_W-1:0]  in_amt,
  input logic [1:0]        in_kind,
  input logic              in_carry,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_carry
);
  localparam logic [SEL_W-1:0] W_K = SEL_W'(DATA_W);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_carry));

  a_r8_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r2_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_amt[SEL_W-1:0] == '0) |=>
      (out_data == $past(in_data)) && (out_carry == $past(in_carry)));

  a_r3_lsl_far: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_kind == 2'd0) && (in_amt[SEL_W-1:0] > W_K) |=>
      (out_data == '0) && !out_carry);

  a_r5_asr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_kind == 2'd2) && (in_amt[SEL_W-1:0] >= W_K) |=>
      (out_data == {DATA_W{$past(in_data[DATA_W-1])}}) &&
      (out_carry == $past(in_data[DATA_W-1])));

  a_r6_rot_pop: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_kind == 2'd3) |=>
      $countones(out_data) == $countones($past(in_data)));
endmodule

bind shift_carry_unit scu_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_amt    (in_amt),
  .in_kind   (in_kind),
  .in_carry  (in_carry),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_carry (out_carry)
);

// File: tb/tb_shift_carry_unit.sv
module tb_shift_carry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [31:0] in_amt = '0;
  logic [1:0]  in_kind = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_carry;

  int n_checks = 0;
  int n_fail = 0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_data = '0;
  logic        exp_carry = 1'b0;

  always #5 clk = ~clk;

  shift_carry_unit dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_amt(in_amt), .in_kind(in_kind), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_carry(out_carry)
  );

  function automatic void ref_shift(input logic [31:0] x, input logic [31:0] a,
                                    input logic [1:0] kd, input logic cin,
                                    output logic [31:0] r, output logic c);
    int k = int'(a & 32'hFF);
    int m;
    r = x;
    c = cin;
    if (k != 0) begin
      case (kd)
        2'd0: begin
          for (int i = 0; i < 32; i++) r[i] = (i - k >= 0) ? x[i-k] : 1'b0;
          c = (k <= 32) ? x[32-k] : 1'b0;
        end
        2'd1: begin
          for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? x[i+k] : 1'b0;
          c = (k <= 32) ? x[k-1] : 1'b0;
        end
        2'd2: begin
          for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? x[i+k] : x[31];
          c = (k < 32) ? x[k-1] : x[31];
        end
        default: begin
          m = k % 32;
          for (int i = 0; i < 32; i++) r[i] = x[(i+m)%32];
          c = (m == 0) ? x[31] : x[m-1];
        end
      endcase
    end
  endfunction

  // reference model: one-entry output register updated on each edge
  always @(posedge clk) begin
    logic [31:0] r;
    logic c;
    if (!rst_n) exp_valid = 1'b0;
    else if (!exp_valid || out_ready) begin
      exp_valid = in_valid;
      if (in_valid) begin
        ref_shift(in_data, in_amt, in_kind, in_carry, r, c);
        exp_data  = r;
        exp_carry = c;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (out_valid !== exp_valid) begin
        n_fail++;
        $display("FAIL R9 model out_valid act=%b exp=%b", out_valid, exp_valid);
      end else if (exp_valid && (out_data !== exp_data || out_carry !== exp_carry)) begin
        n_fail++;
        $display("FAIL R3-6 model act=%h/%b exp=%h/%b", out_data, out_carry, exp_data, exp_carry);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] ad, input logic ac,
                     input logic [31:0] ed, input logic ec);
    n_checks++;
    if (ad !== ed || ac !== ec) begin
      n_fail++;
      $display("FAIL %s act=%h/%b exp=%h/%b", tag, ad, ac, ed, ec);
    end
  endtask

  task automatic one(input string tag, input logic [31:0] x, input logic [31:0] a,
                     input logic [1:0] kd, input logic cin,
                     input logic [31:0] er, input logic ec);
    @(negedge clk); #2;
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = x; in_amt = a; in_kind = kd; in_carry = cin;
    @(negedge clk);
    chk(tag, out_data, out_carry, er, ec);
    #2 in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 reset act=%b/%b exp=0/1", out_valid, in_ready);
    end
    #2 rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 after reset act=%b exp=0", out_valid);
    end

    one("R3 lsl1",   32'h8000_0001, 32'd1,   2'd0, 1'b0, 32'h0000_0002, 1'b1);
    one("R3 lsl31",  32'h0000_0003, 32'd31,  2'd0, 1'b0, 32'h8000_0000, 1'b1);
    one("R3 lsl32",  32'h0000_0001, 32'd32,  2'd0, 1'b0, 32'h0000_0000, 1'b1);
    one("R3 lsl33",  32'hFFFF_FFFF, 32'd33,  2'd0, 1'b1, 32'h0000_0000, 1'b0);
    one("R4 lsr4",   32'h0000_00F8, 32'd4,   2'd1, 1'b0, 32'h0000_000F, 1'b1);
    one("R4 lsr32",  32'h8000_0000, 32'd32,  2'd1, 1'b0, 32'h0000_0000, 1'b1);
    one("R4 lsr40",  32'hFFFF_FFFF, 32'd40,  2'd1, 1'b1, 32'h0000_0000, 1'b0);
    one("R5 asr4",   32'h8000_0010, 32'd4,   2'd2, 1'b1, 32'hF800_0001, 1'b0);
    one("R5 asr200", 32'h8000_0000, 32'd200, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b1);
    one("R5 asr32",  32'h7FFF_FFFF, 32'd32,  2'd2, 1'b1, 32'h0000_0000, 1'b0);
    one("R6 ror8",   32'h1234_5678, 32'd8,   2'd3, 1'b1, 32'h7812_3456, 1'b0);
    one("R6 ror4",   32'h0000_000F, 32'd4,   2'd3, 1'b0, 32'hF000_0000, 1'b1);
    one("R6 ror32",  32'h0000_0001, 32'd32,  2'd3, 1'b1, 32'h0000_0001, 1'b0);
    one("R6 ror64",  32'h8000_0000, 32'd64,  2'd3, 1'b0, 32'h8000_0000, 1'b1);
    one("R2 ror0",   32'h0000_ABCD, 32'd0,   2'd3, 1'b1, 32'h0000_ABCD, 1'b1);
    one("R2 lsl0",   32'h8000_0001, 32'd0,   2'd0, 1'b1, 32'h8000_0001, 1'b1);
    one("R2 asr0",   32'h8000_0001, 32'd0,   2'd2, 1'b0, 32'h8000_0001, 1'b0);
    one("R1 hi104",  32'h0000_00F0, 32'h0000_0104, 2'd1, 1'b1, 32'h0000_000F, 1'b0);
    one("R1 hiFF00", 32'h1234_5678, 32'hFFFF_FF00, 2'd0, 1'b1, 32'h1234_5678, 1'b1);

    // R7 stall: hold output while downstream not ready
    @(negedge clk); #2;
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'h0000_0010; in_amt = 32'd1; in_kind = 2'd0; in_carry = 1'b0;
    @(negedge clk); #2;
    in_data = 32'h0000_0100; in_amt = 32'd4; in_kind = 2'd1;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      n_checks++;
      if (in_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R7 in_ready act=%b exp=0", in_ready);
      end
      chk("R7 held", out_data, out_carry, 32'h0000_0020, 1'b0);
    end
    #2 out_ready = 1'b1;
    @(negedge clk);
    chk("R7 next", out_data, out_carry, 32'h0000_0010, 1'b0);
    #2 in_valid = 1'b0;

    // random traffic with back-pressure, checked by the model
    for (int t = 0; t < 600; t++) begin
      @(negedge clk); #2;
      out_ready = ($urandom % 3) != 0;
      if (!in_valid || in_ready) begin
        in_valid = ($urandom % 4) != 0;
        in_data  = $urandom;
        in_kind  = 2'($urandom % 4);
        in_carry = 1'($urandom % 2);
        in_amt   = (($urandom % 5) == 0) ? $urandom
                                         : ((32'($urandom) << 8) | 32'($urandom % 70));
      end
    end
    @(negedge clk); #2;
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule